// File: doc/BRIEF.md
# I2S Audio Serial Transmitter (Clock Master)

This block drives a three-wire stereo audio bus as clock master. It produces the bit clock by dividing the system clock, and it drives word select and serial data. Audio words come in through a 16-bit write port with a valid/ready handshake. The block holds one complete sample in a small buffer. At the start of each 32-bit channel slot it moves that sample into a shift register and sends it MSB first. A frame is a left slot followed by a right slot.

Two framings are supported: Philips, where the data lags word select by one bit, and MSB-justified, where the data is aligned with word select. Samples are 16 bits (one write per slot) or 24 bits (two writes per slot), and each is zero-padded to fill the 32-bit slot. The idle level of the bit clock can be set low or high. If the buffer does not hold a complete sample when a slot begins, the slot is sent as zeros and a sticky underrun flag is raised. The mode inputs are meant to change only while the block is disabled.

Top module: `i2s_tx`

## Requirements
- R1: While the block is disabled, and after reset, the outputs are at idle levels. `bitClk` equals `idleHigh` and `serData` is 0. `wordSel` is 1 in Philips framing (`msbMode`=0) and 0 in MSB-justified framing (`msbMode`=1). After reset, `underrun` is 0 and `wrReady` is 1.
- R2: While running, the bit period is 2×`halfPer` system clocks (`halfPer` ≥ 1). The bit clock toggles every `halfPer` clocks. `serData` and `wordSel` change only in the cycle where the bit clock returns to its idle level.
- R3: With `idleHigh`=1 the bit clock idles high and is the inverse of the waveform produced with `idleHigh`=0.
- R4: A frame is 64 bit periods: a 32-bit left slot, then a 32-bit right slot. Complete samples are sent in the order they were written, alternating left and right, with the first sample after enable going to the left slot.
- R5: With `wide24`=0, one write is one sample. Its 16 bits are sent MSB first, and the rest of the slot is zeros.
- R6: With `wide24`=1, a sample D[23:0] takes two writes. The first write carries D[23:8]. The second write carries D[7:0] in bits 15:8, and its bits 7:0 are ignored. The sample is sent MSB first, followed by 8 zero bits.
- R7: In Philips framing, `wordSel` is 0 during the left slot and 1 during the right slot. The MSB appears one bit period after the `wordSel` change, so the first bit of every slot is 0.
- R8: In MSB-justified framing, `wordSel` is 1 during the left slot and 0 during the right slot. The MSB is sent in the same bit period as the `wordSel` change.
- R9: If a complete sample is not buffered when a slot begins, the slot is all zeros and `underrun` goes to 1. A partially written 24-bit sample is kept. `underrun` stays at 1 until an `underrunClr` pulse clears it. If a new underrun happens in the same cycle as the clear, the flag stays at 1.
- R10: `wrReady` is 1 whenever the buffer holds less than a complete sample. A word is accepted in a cycle where both `wrValid` and `wrReady` are 1. Words can be accepted while the block is disabled.
- R11: When `enable` rises, the first bit of a left slot begins in the next cycle. When `enable` falls, the outputs return to idle levels in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the transmitter while high |
| msbMode | input | 1 | 0 = Philips framing, 1 = MSB-justified framing |
| wide24 | input | 1 | 0 = 16-bit samples, 1 = 24-bit samples |
| idleHigh | input | 1 | Idle level of the bit clock |
| halfPer | input | DIV_W | Bit-clock half period, in system clocks |
| wrData | input | 16 | Audio word |
| wrValid | input | 1 | A word is offered on `wrData` |
| wrReady | output | 1 | The buffer can accept a word |
| underrunClr | input | 1 | Pulse high to clear the underrun flag |
| underrun | output | 1 | Sticky underrun flag |
| bitClk | output | 1 | Bit clock |
| wordSel | output | 1 | Word select (channel indicator) |
| serData | output | 1 | Serial data |

## Verification
The checker tests on every cycle that serial data and word select change only on the edge where the bit clock returns to idle. It also checks that the padding bits of each slot are zero in both sample widths, that word select matches the slot for each framing, that the underrun flag is set and stays set, and that the outputs go idle once the block is disabled. Only the bench scenarios show the actual bit order of the samples, the left-then-right order, the splitting of 24-bit samples across two writes, and the correct bit period. The same applies to the inverted clock polarity, restarting at a left slot after a mid-frame disable, and the handling of a partially written 24-bit sample at an underrun. For these, a behavioural model computes each expected bit from the time since enable and the queue of written words.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int SLOT_LEN = 32;
  localparam int IDX_W    = 6;   // bit index across a left+right frame
  localparam int WORD_W   = 16;

  typedef struct packed {
    logic bitStart;   // a new bit period starts after this edge
    logic slotLoad;   // that bit is the first bit of a slot
    logic rightSlot;  // that bit belongs to the right slot
  } txStrobe_t;
endpackage

// File: rtl/i2s_tx_ctrl.sv
module i2s_tx_ctrl
  import i2s_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] halfPer,
  output txStrobe_t        strb,
  output logic             run,
  output logic             phase,
  output logic [IDX_W-1:0] bitIdx
);
  logic [DIV_W-1:0] divCnt;
  logic             startNow;
  logic             halfEnd;
  logic             bitEnd;
  logic [IDX_W-1:0] nextIdx;

  assign startNow = enable && !run;
  assign halfEnd  = run && (divCnt == halfPer - 1'b1);
  assign bitEnd   = halfEnd && phase;
  assign nextIdx  = startNow ? '0 : bitIdx + 1'b1;

  always_comb begin
    strb.bitStart  = startNow || (enable && bitEnd);
    strb.slotLoad  = strb.bitStart && (nextIdx[IDX_W-2:0] == '0);
    strb.rightSlot = nextIdx[IDX_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      run    <= 1'b0;
      phase  <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (!enable) begin
      run    <= 1'b0;
      phase  <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (startNow) begin
      run    <= 1'b1;
      phase  <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (halfEnd) begin
      divCnt <= '0;
      phase  <= !phase;
      if (phase) bitIdx <= nextIdx;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2s_tx_dp.sv
module i2s_tx_dp
  import i2s_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic              msbMode,
  input  logic              wide24,
  input  logic [WORD_W-1:0] wrData,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic              underrunClr,
  output logic              underrun,
  output logic              sdReg,
  output logic              wsReg,
  output logic              bufFull
);
  localparam int LOW_W = SLOT_LEN - WORD_W - 8;

  logic [1:0]          wordCnt;
  logic [WORD_W-1:0]   hiWord;
  logic [7:0]          loByte;
  logic [SLOT_LEN-1:0] shifter;
  logic [SLOT_LEN-1:0] slotWord;
  logic                accept;

  assign bufFull = wide24 ? (wordCnt == 2'd2) : (wordCnt != 2'd0);
  assign wrReady = !bufFull;
  assign accept  = wrValid && wrReady;

  always_comb begin
    if (!bufFull)    slotWord = '0;
    else if (wide24) slotWord = {hiWord, loByte, {LOW_W{1'b0}}};
    else             slotWord = {hiWord, {(SLOT_LEN-WORD_W){1'b0}}};
  end

  // sample buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCnt <= '0;
      hiWord  <= '0;
      loByte  <= '0;
    end else if (strb.slotLoad && bufFull) begin
      wordCnt <= '0;
    end else if (accept) begin
      if (wordCnt == 2'd0) hiWord <= wrData;
      else                 loByte <= wrData[WORD_W-1 -: 8];
      wordCnt <= wordCnt + 1'b1;
    end
  end

  // serializer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shifter <= '0;
      sdReg   <= 1'b0;
      wsReg   <= 1'b0;
    end else if (strb.bitStart) begin
      wsReg <= strb.rightSlot ^ msbMode;
      if (strb.slotLoad) begin
        if (msbMode) begin
          sdReg   <= slotWord[SLOT_LEN-1];
          shifter <= slotWord << 1;
        end else begin
          sdReg   <= 1'b0;
          shifter <= slotWord;
        end
      end else begin
        sdReg   <= shifter[SLOT_LEN-1];
        shifter <= shifter << 1;
      end
    end
  end

  // sticky underrun flag, set wins over clear
  always_ff @(posedge clk) begin
    if (!rstN)                           underrun <= 1'b0;
    else if (strb.slotLoad && !bufFull)  underrun <= 1'b1;
    else if (underrunClr)                underrun <= 1'b0;
  end
endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
  import i2s_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             msbMode,
  input  logic             wide24,
  input  logic             idleHigh,
  input  logic [DIV_W-1:0] halfPer,
  input  logic [15:0]      wrData,
  input  logic             wrValid,
  output logic             wrReady,
  input  logic             underrunClr,
  output logic             underrun,
  output logic             bitClk,
  output logic             wordSel,
  output logic             serData
);
  txStrobe_t        strb;
  logic             run;
  logic             phase;
  logic [IDX_W-1:0] bitIdx;
  logic             sdReg;
  logic             wsReg;
  logic             bufFull;

  i2s_tx_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .halfPer (halfPer),
    .strb    (strb),
    .run     (run),
    .phase   (phase),
    .bitIdx  (bitIdx)
  );

  i2s_tx_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .msbMode     (msbMode),
    .wide24      (wide24),
    .wrData      (wrData),
    .wrValid     (wrValid),
    .wrReady     (wrReady),
    .underrunClr (underrunClr),
    .underrun    (underrun),
    .sdReg       (sdReg),
    .wsReg       (wsReg),
    .bufFull     (bufFull)
  );

  assign bitClk  = phase ^ idleHigh;
  assign wordSel = run ? wsReg : !msbMode;
  assign serData = run && sdReg;
endmodule

// File: rtl/i2s_tx_chk.sv
module i2s_tx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       msbMode,
  input logic       wide24,
  input logic       idleHigh,
  input logic       bitClk,
  input logic       wordSel,
  input logic       serData,
  input logic       underrun,
  input logic       underrunClr,
  input logic       run,
  input logic [5:0] bitIdx,
  input logic       slotLoad,
  input logic       bufFull
);
  logic pastOk;
  always_ff @(posedge clk) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  a_r2_sd_on_trailing: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && run && $past(run) && (serData != $past(serData))
    |-> (bitClk == idleHigh) && ($past(bitClk) != idleHigh));

  a_r2_ws_on_trailing: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && run && $past(run) && (wordSel != $past(wordSel))
    |-> (bitClk == idleHigh) && ($past(bitClk) != idleHigh));

  a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    run && !wide24 &&
    (msbMode ? (bitIdx[4:0] >= 5'd16) : ((bitIdx[4:0] >= 5'd17) || (bitIdx[4:0] == 5'd0)))
    |-> !serData);

  a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    run && wide24 &&
    (msbMode ? (bitIdx[4:0] >= 5'd24) : ((bitIdx[4:0] >= 5'd25) || (bitIdx[4:0] == 5'd0)))
    |-> !serData);

  a_r7_philips_ws: assert property (@(posedge clk) disable iff (!rstN)
    run && !msbMode |-> wordSel == bitIdx[5]);

  a_r8_msbj_ws: assert property (@(posedge clk) disable iff (!rstN)
    run && msbMode |-> wordSel == !bitIdx[5]);

  a_r9_underrun_set: assert property (@(posedge clk) disable iff (!rstN)
    slotLoad && !bufFull |=> underrun);

  a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    underrun && !underrunClr |=> underrun);

  a_r11_halt_idle: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && !$past(enable) |-> (bitClk == idleHigh) && !serData && !run);
endmodule

bind i2s_tx i2s_tx_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .msbMode     (msbMode),
  .wide24      (wide24),
  .idleHigh    (idleHigh),
  .bitClk      (bitClk),
  .wordSel     (wordSel),
  .serData     (serData),
  .underrun    (underrun),
  .underrunClr (underrunClr),
  .run         (run),
  .bitIdx      (bitIdx),
  .slotLoad    (strb.slotLoad),
  .bufFull     (bufFull)
);

// File: tb/sim_i2s_tx.sv
`timescale 1ns/1ps
module sim_i2s_tx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       msbMode = 1'b0;
  logic       wide24 = 1'b0;
  logic       idleHigh = 1'b0;
  logic [7:0] halfPer = 8'd1;
  logic [15:0] wrData = '0;
  logic       wrValid = 1'b0;
  logic       underrunClr = 1'b0;
  logic       wrReady, underrun, bitClk, wordSel, serData;

  always #2 clk = !clk;

  i2s_tx #(.DIV_W(8)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .msbMode(msbMode), .wide24(wide24),
    .idleHigh(idleHigh), .halfPer(halfPer), .wrData(wrData), .wrValid(wrValid),
    .wrReady(wrReady), .underrunClr(underrunClr), .underrun(underrun),
    .bitClk(bitClk), .wordSel(wordSel), .serData(serData)
  );

  int nChecks = 0;
  int nFail = 0;

  // bench-side stimulus and model state
  bit          enReq = 0;
  bit          clrReq = 0;
  bit          feedOn = 0;
  logic [15:0] feedQ[$];
  logic [15:0] mBuf[$];
  bit          mRun = 0;
  bit          mUnder = 0;
  int          mT = 0;
  logic [31:0] mW = '0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int  h, k, p, slot, need;
    bit  eClk, eWs, eSd;
    string lbl;
    h = int'(halfPer);
    need = wide24 ? 2 : 1;
    if (mRun) begin
      k    = (mT / (2*h)) % 64;
      slot = k / 32;
      p    = k % 32;
      eClk = ((mT % (2*h)) >= h) ^ idleHigh;
      eWs  = slot[0] ^ msbMode;
      if (msbMode)     eSd = mW[31-p];
      else if (p == 0) eSd = 1'b0;
      else             eSd = mW[32-p];
      lbl = (mT == 0) ? "R11" : (msbMode ? "R8" : "R7");
      chk(idleHigh ? "R3" : "R2", "bitClk", 32'(bitClk), 32'(eClk));
      chk(lbl, "wordSel", 32'(wordSel), 32'(eWs));
      chk(wide24 ? "R4 R6" : "R4 R5", "serData", 32'(serData), 32'(eSd));
    end else begin
      chk("R1", "idle bitClk", 32'(bitClk), 32'(idleHigh));
      chk("R1", "idle wordSel", 32'(wordSel), 32'(!msbMode));
      chk("R1", "idle serData", 32'(serData), 32'd0);
    end
    chk("R10", "wrReady", 32'(wrReady), 32'(mBuf.size() < need));
    chk("R9", "underrun", 32'(underrun), 32'(mUnder));
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      int  h, need;
      bit  full, acc, setU, doLoad;
      @(negedge clk);
      if (rstN) compare();
      enable      = enReq;
      wrValid     = feedOn && (feedQ.size() > 0);
      wrData      = (feedQ.size() > 0) ? feedQ[0] : 16'h0;
      underrunClr = clrReq;
      clrReq      = 0;
      if (!rstN) begin
        mRun = 0; mUnder = 0; mT = 0; mW = '0; mBuf.delete();
      end else begin
        h = int'(halfPer);
        need = wide24 ? 2 : 1;
        full = mBuf.size() >= need;
        acc  = wrValid && !full;
        setU = 0;
        doLoad = 0;
        if (mRun && !enable) mRun = 0;
        else if (!mRun && enable) begin
          mRun = 1; mT = 0; doLoad = 1;
        end else if (mRun) begin
          mT++;
          if ((mT % (2*h) == 0) && ((mT / (2*h)) % 32 == 0)) doLoad = 1;
        end
        if (doLoad) begin
          if (full) begin
            if (need == 1) mW = {mBuf[0], 16'h0};
            else           mW = {mBuf[0], mBuf[1][15:8], 8'h0};
            mBuf.delete();
          end else begin
            mW = '0;
            setU = 1;
          end
        end
        if (setU) mUnder = 1;
        else if (underrunClr) mUnder = 0;
        if (acc) begin
          mBuf.push_back(wrData);
          void'(feedQ.pop_front());
        end
      end
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
  endtask

  initial begin
    #(200000 * 4);
    nFail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    step(4);
    rstN = 1'b1;
    step(1);
    @(negedge clk);
    chk("R1", "reset wrReady", 32'(wrReady), 32'd1);
    chk("R1", "reset underrun", 32'(underrun), 32'd0);
    chk("R1", "reset bitClk", 32'(bitClk), 32'd0);
    chk("R1", "reset wordSel", 32'(wordSel), 32'd1);
    chk("R1", "reset serData", 32'(serData), 32'd0);

    // A: Philips, 16-bit, idle low, fastest clock, then starve
    for (int i = 0; i < 8; i++) feedQ.push_back(16'hA5C3 + 16'(i * 16'h1357));
    feedOn = 1;
    step(4);
    enReq = 1;
    step(700);
    clrReq = 1;
    step(40);
    enReq = 0;
    step(6);

    // B: MSB-justified, 24-bit, idle high, half period 3, junk low bytes
    msbMode = 1; wide24 = 1; idleHigh = 1; halfPer = 8'd3;
    feedQ.delete();
    for (int i = 0; i < 12; i++) feedQ.push_back(16'h8E71 ^ 16'(i * 16'h2B3D));
    step(6);
    clrReq = 1;
    step(2);
    enReq = 1;
    step(1250);
    enReq = 0;
    step(6);

    // C: Philips, 24-bit, half period 2, start starved, partial sample at a slot start
    msbMode = 0; wide24 = 1; idleHigh = 0; halfPer = 8'd2;
    feedOn = 0;
    feedQ.delete();
    enReq = 1;
    step(60);
    clrReq = 1;
    feedQ.push_back(16'hF00D);
    feedOn = 1;
    step(200);
    for (int i = 0; i < 6; i++) feedQ.push_back(16'h3C5A + 16'(i * 16'h0F0F));
    step(600);
    enReq = 0;
    step(4);

    // D: MSB-justified, 16-bit, disable mid-frame and restart on a left slot
    msbMode = 1; wide24 = 0; halfPer = 8'd1;
    feedQ.delete();
    for (int i = 0; i < 10; i++) feedQ.push_back(16'h1234 + 16'(i * 16'h4321));
    step(4);
    enReq = 1;
    step(90);
    enReq = 0;
    step(3);
    enReq = 1;
    clrReq = 1;
    step(400);
    enReq = 0;
    step(4);

    summary();
    $finish;
  end
endmodule